// File: doc/BRIEF.md
# Series Cell Charge/Discharge Protection Controller

This controller guards a stack of three or four series lithium cells. Comparators outside the block report four flags per cell: above the overcharge trip, below the overcharge release level, below the undercharge trip, and above the undercharge release level. The controller visits one cell for each `sample_tick` and presents the visited index on `cell_sel`. It decides from these flags whether the charge switch and the discharge switch may conduct. A low `three_cell` input selects four cells, and the board pulls that input low, so an open connection also gives four cells.

There are three states. `ST_RUN` keeps both switches on. `ST_OVHOLD` blocks charging after an overcharge. While in `ST_OVHOLD`, the charge switch turns back on whenever discharge current is sensed, so load current does not have to pass through the switch's body diode. `ST_SLEEP` opens both switches after an undercharge and then waits for a charger. The transitions are as follows:
- RUN→OVHOLD on a confirmed overcharge.
- RUN→SLEEP and OVHOLD→SLEEP on a confirmed undercharge.
- OVHOLD→RUN once every active cell reports release.
- SLEEP→RUN when a charger is present and every active cell reports undercharge release.

While asleep with a charger attached, the charge switch is pulsed.

Top module: `cell_guard_ctrl`

## Requirements
- R1: `cell_sel` advances by one on each `sample_tick`. It returns to 0 after index 3 when `three_cell` is low (four cells) and after index 2 when `three_cell` is high (three cells).
- R2: In three-cell mode, flags at index 3 have no effect on either switch, including its overcharge flag and its release flag.
- R3: A fault is acted on only on the tick where the same cell shows it for the second visit in a row. A fault seen on one visit and then gone changes neither switch.
- R4: A confirmed overcharge turns `chg_on` off while `dsg_on` stays high. Charging stays blocked until every active cell has been visited with its release flag high. After that, the controller returns to RUN.
- R5: In OVHOLD, `chg_on` follows `dsg_i_det` (subject to R6).
- R6: `chg_on` is low whenever `chg_req` is low.
- R7: A confirmed undercharge turns off both switches and raises `asleep`, from RUN or from OVHOLD. If an overcharge and an undercharge are confirmed on the same tick, sleep wins.
- R8: SLEEP is left only while `wake_chg` is high and every active cell has shown undercharge release since sleep began. Leaving it restores both switches.
- R9: In SLEEP with `wake_chg` high, `chg_on` is high for `PULSE_ON` clocks and then low for `PULSE_OFF` clocks, repeating. The first clock of the pattern is high.
- R10: With `rst_n` low at a clock edge, the controller goes to RUN with `cell_sel` = 0, `asleep` low and `dsg_on` high. `chg_on` is then high if `chg_req` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sample_tick | input | 1 | One-clock pulse that scans the selected cell |
| three_cell | input | 1 | High: three cells; low: four cells |
| chg_req | input | 1 | Charging permitted |
| wake_chg | input | 1 | Charger detected |
| dsg_i_det | input | 1 | Discharge current above the sense threshold |
| ov_hi | input | NCELL | Per cell: above overcharge trip |
| ov_rel | input | NCELL | Per cell: below overcharge release |
| uv_lo | input | NCELL | Per cell: below undercharge trip |
| uv_rel | input | NCELL | Per cell: above undercharge release |
| chg_on | output | 1 | Charge switch command |
| dsg_on | output | 1 | Discharge switch command |
| asleep | output | 1 | SLEEP state flag |
| cell_sel | output | $clog2(NCELL) | Index of the cell being scanned |

## Verification
Overcharge and undercharge confirmation can land on the same scan tick when one cell raises both flags on two consecutive visits. The bench provokes this on cell 1 and expects SLEEP with both switches off, not OVHOLD. A second overlap is smart discharge against the charge request in OVHOLD: discharge current is asserted while `chg_req` is low, and `chg_on` must stay low.

// File: rtl/cg_pkg.sv
package cg_pkg;
    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_OVHOLD = 2'd1,
        ST_SLEEP  = 2'd2
    } cg_state_e;
endpackage

// File: rtl/cg_scan.sv
module cg_scan #(
    parameter int NCELL = 4,
    parameter int SW    = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          three_mode,
    output logic [SW-1:0] sel
);
    localparam logic [SW-1:0] LAST_FULL  = SW'(NCELL - 1);
    localparam logic [SW-1:0] LAST_SHORT = SW'(NCELL - 2);

    logic [SW-1:0] last;
    assign last = three_mode ? LAST_SHORT : LAST_FULL;

    always_ff @(posedge clk) begin
        if (!rst_n)
            sel <= '0;
        else if (tick)
            sel <= (sel >= last) ? '0 : sel + 1'b1;
    end

    // R1
    short_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && three_mode) |=> (sel != LAST_FULL));
    // R1
    full_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !three_mode && sel == LAST_FULL) |=> (sel == '0));
endmodule

// File: rtl/cg_cell_track.sv
module cg_cell_track (
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic clr_strk,
    input  logic clr_rel,
    input  logic clr_up,
    input  logic f_ovh,
    input  logic f_ovr,
    input  logic f_uvl,
    input  logic f_uvr,
    output logic ov_cfm,
    output logic uv_cfm,
    output logic rel_ok,
    output logic up_ok
);
    logic ov_strk, uv_strk;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ov_strk <= 1'b0;
            uv_strk <= 1'b0;
        end else if (clr_strk) begin
            ov_strk <= 1'b0;
            uv_strk <= 1'b0;
        end else if (hit) begin
            ov_strk <= f_ovh;
            uv_strk <= f_uvl;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr_rel)
            rel_ok <= 1'b0;
        else if (hit)
            rel_ok <= f_ovr;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr_up)
            up_ok <= 1'b0;
        else if (hit)
            up_ok <= f_uvr;
    end

    assign ov_cfm = hit && f_ovh && ov_strk;
    assign uv_cfm = hit && f_uvl && uv_strk;

    // R4
    rel_on_scan_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rel_ok) |-> $past(hit && f_ovr));
    // R8
    up_on_scan_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(up_ok) |-> $past(hit && f_uvr));
endmodule

// File: rtl/cg_pulse.sv
module cg_pulse #(
    parameter int PULSE_ON  = 7,
    parameter int PULSE_OFF = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic phase_on
);
    localparam int PMAX = (PULSE_ON > PULSE_OFF) ? PULSE_ON : PULSE_OFF;
    localparam int CW   = $clog2(PMAX + 1);
    localparam logic [CW-1:0] ON_END  = CW'(PULSE_ON - 1);
    localparam logic [CW-1:0] OFF_END = CW'(PULSE_OFF - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt      <= '0;
            phase_on <= 1'b1;
        end else if (phase_on) begin
            if (cnt == ON_END) begin
                cnt      <= '0;
                phase_on <= 1'b0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end else begin
            if (cnt == OFF_END) begin
                cnt      <= '0;
                phase_on <= 1'b1;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // R9
    pulse_off_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(phase_on) |-> $past(run));
endmodule

// File: rtl/cell_guard_ctrl.sv
module cell_guard_ctrl
    import cg_pkg::*;
#(
    parameter int NCELL     = 4,
    parameter int PULSE_ON  = 7,
    parameter int PULSE_OFF = 10,
    localparam int SW       = $clog2(NCELL)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sample_tick,
    input  logic             three_cell,
    input  logic             chg_req,
    input  logic             wake_chg,
    input  logic             dsg_i_det,
    input  logic [NCELL-1:0] ov_hi,
    input  logic [NCELL-1:0] ov_rel,
    input  logic [NCELL-1:0] uv_lo,
    input  logic [NCELL-1:0] uv_rel,
    output logic             chg_on,
    output logic             dsg_on,
    output logic             asleep,
    output logic [SW-1:0]    cell_sel
);
    localparam logic [NCELL-1:0] MASK_FULL  = '1;
    localparam logic [NCELL-1:0] MASK_SHORT = {1'b0, {(NCELL-1){1'b1}}};

    cg_state_e        state, nxt;
    logic [NCELL-1:0] hit, ov_cfm, uv_cfm, rel_ok, up_ok;
    logic [NCELL-1:0] act;
    logic             all_rel, all_up, any_ov, any_uv, pulse_hi;

    cg_scan #(.NCELL(NCELL), .SW(SW)) u_scan (
        .clk(clk), .rst_n(rst_n), .tick(sample_tick),
        .three_mode(three_cell), .sel(cell_sel)
    );

    for (genvar i = 0; i < NCELL; i++) begin : g_cell
        assign hit[i] = sample_tick && (cell_sel == SW'(i));
        cg_cell_track u_trk (
            .clk(clk), .rst_n(rst_n), .hit(hit[i]),
            .clr_strk(state == ST_SLEEP),
            .clr_rel(state != ST_OVHOLD),
            .clr_up(state != ST_SLEEP),
            .f_ovh(ov_hi[i]), .f_ovr(ov_rel[i]),
            .f_uvl(uv_lo[i]), .f_uvr(uv_rel[i]),
            .ov_cfm(ov_cfm[i]), .uv_cfm(uv_cfm[i]),
            .rel_ok(rel_ok[i]), .up_ok(up_ok[i])
        );
    end

    cg_pulse #(.PULSE_ON(PULSE_ON), .PULSE_OFF(PULSE_OFF)) u_pulse (
        .clk(clk), .rst_n(rst_n),
        .run((state == ST_SLEEP) && wake_chg),
        .phase_on(pulse_hi)
    );

    assign act     = three_cell ? MASK_SHORT : MASK_FULL;
    assign all_rel = &(rel_ok | ~act);
    assign all_up  = &(up_ok | ~act);
    assign any_ov  = |ov_cfm;
    assign any_uv  = |uv_cfm;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_RUN: begin
                if (any_uv)      nxt = ST_SLEEP;
                else if (any_ov) nxt = ST_OVHOLD;
            end
            ST_OVHOLD: begin
                if (any_uv)                nxt = ST_SLEEP;
                else if (all_rel && !any_ov) nxt = ST_RUN;
            end
            ST_SLEEP: begin
                if (wake_chg && all_up) nxt = ST_RUN;
            end
            default: nxt = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= nxt;
    end

    always_comb begin
        chg_on = 1'b0;
        dsg_on = 1'b1;
        asleep = 1'b0;
        unique case (state)
            ST_RUN:    chg_on = chg_req;
            ST_OVHOLD: chg_on = chg_req && dsg_i_det;
            ST_SLEEP: begin
                chg_on = chg_req && wake_chg && pulse_hi;
                dsg_on = 1'b0;
                asleep = 1'b1;
            end
            default: chg_on = 1'b0;
        endcase
    end

    // R7
    sleep_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(asleep) |-> $past(sample_tick));
    // R8
    sleep_exit_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(asleep) |-> $past(wake_chg));
    // R4
    hold_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OVHOLD && $past(state) == ST_RUN) |-> $past(sample_tick));
    // R6
    chg_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chg_on |-> chg_req);
endmodule

// File: tb/sim_cell_guard_ctrl.sv
module sim_cell_guard_ctrl;
    logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, three = 1'b0;
    logic req = 1'b1, wake = 1'b0, idet = 1'b0;
    logic [3:0] ovh = 4'h0, ovr = 4'hF, uvl = 4'h0, uvr = 4'hF;
    logic chg, dsg, slp;
    logic [1:0] sel;
    int checks = 0, errors = 0;

    always #4 clk = ~clk;

    cell_guard_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .sample_tick(tick), .three_cell(three),
        .chg_req(req), .wake_chg(wake), .dsg_i_det(idet),
        .ov_hi(ovh), .ov_rel(ovr), .uv_lo(uvl), .uv_rel(uvr),
        .chg_on(chg), .dsg_on(dsg), .asleep(slp), .cell_sel(sel)
    );

    typedef struct packed {
        logic [3:0] ovh, ovr, uvl, uvr;
        logic       three, req, wake, idet;
        logic [1:0] rounds, e_chg;
        logic       e_dsg, e_sl;
    } vec_t;

    // e_chg 2 = not checked
    localparam logic [25:0] TBL [14] = '{
        {4'h0,4'hF,4'h0,4'hF,1'b0,1'b1,1'b0,1'b0,2'd1,2'd1,1'b1,1'b0},
        {4'h4,4'hB,4'h0,4'hF,1'b0,1'b1,1'b0,1'b0,2'd1,2'd1,1'b1,1'b0},
        {4'h4,4'hB,4'h0,4'hF,1'b0,1'b1,1'b0,1'b0,2'd1,2'd0,1'b1,1'b0},
        {4'h0,4'hB,4'h0,4'hF,1'b0,1'b1,1'b0,1'b0,2'd1,2'd0,1'b1,1'b0},
        {4'h0,4'hB,4'h0,4'hF,1'b0,1'b1,1'b0,1'b1,2'd0,2'd1,1'b1,1'b0},
        {4'h0,4'hB,4'h0,4'hF,1'b0,1'b0,1'b0,1'b1,2'd0,2'd0,1'b1,1'b0},
        {4'h0,4'hF,4'h0,4'hF,1'b0,1'b1,1'b0,1'b0,2'd1,2'd1,1'b1,1'b0},
        {4'h0,4'hF,4'h1,4'hE,1'b0,1'b1,1'b0,1'b0,2'd1,2'd1,1'b1,1'b0},
        {4'h0,4'hF,4'h1,4'hE,1'b0,1'b1,1'b0,1'b0,2'd1,2'd0,1'b0,1'b1},
        {4'h0,4'hF,4'h1,4'hE,1'b0,1'b1,1'b1,1'b0,2'd1,2'd2,1'b0,1'b1},
        {4'h0,4'hF,4'h0,4'hF,1'b0,1'b1,1'b1,1'b0,2'd1,2'd1,1'b1,1'b0},
        {4'h8,4'h7,4'h0,4'hF,1'b1,1'b1,1'b0,1'b0,2'd3,2'd1,1'b1,1'b0},
        {4'h4,4'h3,4'h0,4'hF,1'b1,1'b1,1'b0,1'b0,2'd2,2'd0,1'b1,1'b0},
        {4'h0,4'h7,4'h0,4'hF,1'b1,1'b1,1'b0,1'b0,2'd1,2'd1,1'b1,1'b0}
    };
    localparam string TAGS [14] = '{"R10","R3","R4","R4","R5","R6","R4",
                                    "R3","R7","R8","R8","R2","R1","R2"};

    task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic tick_once();
        @(negedge clk) tick = 1'b1;
        @(negedge clk) tick = 1'b0;
    endtask

    task automatic run_rounds(input int n);
        repeat (n * (three ? 3 : 4)) tick_once();
        repeat (2) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk) rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int on_cnt;
        vec_t v;
        do_reset();
        // R10 reset state
        chk("R10", {1'b0, chg, dsg, slp}, 4'b0110);
        chk("R10", {2'b00, sel}, 4'h0);

        for (int i = 0; i < 14; i++) begin
            v = vec_t'(TBL[i]);
            ovh = v.ovh; ovr = v.ovr; uvl = v.uvl; uvr = v.uvr;
            three = v.three; req = v.req; wake = v.wake; idet = v.idet;
            run_rounds(int'(v.rounds));
            if (v.e_chg != 2'd2) chk(TAGS[i], {3'b0, chg}, {3'b0, v.e_chg[0]});
            chk(TAGS[i], {3'b0, dsg}, {3'b0, v.e_dsg});
            chk(TAGS[i], {3'b0, slp}, {3'b0, v.e_sl});
            chk("R1", {2'b00, sel}, 4'h0);
        end

        // R6: request low in RUN blocks charge only
        three = 1'b0; ovh = 0; ovr = 4'hF; uvl = 0; uvr = 4'hF; idet = 0; wake = 0;
        req = 1'b0; repeat (2) @(negedge clk);
        chk("R6", {1'b0, chg, dsg, slp}, 4'b0010);
        req = 1'b1;

        // R7: over and under confirmed on the same tick on cell 1 -> sleep
        ovh = 4'h2; ovr = 4'hD; uvl = 4'h2; uvr = 4'hD;
        run_rounds(2);
        chk("R7", {1'b0, chg, dsg, slp}, 4'b0001);
        ovh = 0; ovr = 4'hF;

        // R9: charge pulsing while asleep with a charger present
        wake = 1'b1; #1;
        on_cnt = 0;
        for (int j = 0; j < 18; j++) begin
            if (j < 17 && chg) on_cnt++;
            if (j == 7)  chk("R9", {3'b0, chg}, 4'h0);
            if (j == 16) chk("R9", {3'b0, chg}, 4'h0);
            if (j == 17) chk("R9", {3'b0, chg}, 4'h1);
            @(negedge clk); #1;
        end
        chk("R9", 4'(on_cnt), 4'd7);
        chk("R8", {3'b0, slp}, 4'h1);

        // R8: released cells without charger keep sleep; charger then wakes
        wake = 1'b0; uvl = 0; uvr = 4'hF;
        run_rounds(2);
        chk("R8", {1'b0, chg, dsg, slp}, 4'b0001);
        wake = 1'b1; repeat (2) @(negedge clk);
        chk("R8", {1'b0, chg, dsg, slp}, 4'b0110);
        wake = 1'b0;

        // R3: undercharge on alternate visits never confirms
        uvl = 4'h1; uvr = 4'hE; run_rounds(1);
        uvl = 4'h0; uvr = 4'hF; run_rounds(1);
        uvl = 4'h1; uvr = 4'hE; run_rounds(1);
        chk("R3", {1'b0, chg, dsg, slp}, 4'b0110);

        // R10: reset out of sleep with a nonzero index
        run_rounds(1);
        chk("R7", {3'b0, slp}, 4'h1);
        tick_once();
        chk("R1", {2'b00, sel}, 4'h1);
        uvl = 0; uvr = 4'hF;
        do_reset();
        chk("R10", {1'b0, chg, dsg, slp}, 4'b0110);
        chk("R10", {2'b00, sel}, 4'h0);

        finish_run();
    end
endmodule